// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block decides, on every clock, whether each of four transmit queues may send. It turns a free-running seconds/nanoseconds time input into one nanosecond count. It compares that count against a programmed cycle anchor and derives the offset into the current cycle. Each queue's gate is open while that offset lies inside the queue's own window. A per-queue strict option goes further: a frame may start only when the frame of the requested length would finish inside both the window and the cycle.

Software programs the block through a simple register write port. The schedule is committed when the nanoseconds word of the start time is written. A start time that is already past snaps forward to the next cycle boundary. If a schedule was already running, that reprogramming also counts as a configuration error. An optional two-step write arms a schedule that begins at a future start time instead of at once. A per-link-speed transmit offset is presented for the launch path.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, and whenever no schedule is running, every gate_open and may_start bit is 1, tx_ofs_ns is 0 unless its enable is set, and cfg_err_cnt is 0 after reset. The reset windows are start 0 and end 1,000,000,000 ns, and the reset cycle is 1,000,000,000 ns.
- R2: With a schedule active, the cycle offset is (now − anchor) mod cycle, where now = sec×10^9 + nsec. Queue q's gate is open exactly when start_q ≤ offset < end_q.
- R3: A committed start time that lies ahead of now leaves all gates open (idle rule) until now reaches it. The first cycle begins exactly there.
- R4: A committed start time b that is earlier than now becomes b + (n+1)×cycle, with n = floor((now − b)/cycle).
- R5: A commit with a past start time while a schedule is already running (active or pending) increments cfg_err_cnt. The counter saturates at 2^ERRW − 1. Commits made while idle leave it unchanged.
- R6: When the future bit is set and no schedule is running or armed, a commit of nanoseconds value 0 only arms. The next commit starts the schedule at its future start time (R3). A future start committed while idle and unarmed starts the cycle at once, with the anchor equal to the current time.
- R7: Speed codes 0, 1, 2 and 3 mean 10 Mb/s, 100 Mb/s, 1 Gb/s and 2.5 Gb/s, with bit times of 100, 10, 1 and 0.4 ns; any other code uses 1 ns. For a strict queue, may_start is 1 only when the gate is open and offset + len×8×bit time ≤ end_q and ≤ cycle.
- R8: For a non-strict queue with an active schedule, may_start equals gate_open.
- R9: When the launch bit is set, tx_ofs_ns is 9600, 960, 184 or 72 for speed codes 0 to 3, and 0 for any other code. When the launch bit is clear, tx_ofs_ns is 0.
- R10: Writing the control word with bit 0 clear stops the schedule and drops any arming, so all gates return to the idle rule. Commits while bit 0 is clear are ignored.
- R11: Register word addresses:
  - 0 is control: bit 0 enable, bit 1 future, bit 2 launch, bits 4..7 strict per queue.
  - 1 is the cycle in ns.
  - 2 is the start seconds.
  - 3 is the start nanoseconds, which commits.
  - 4+2q is the window start of queue q, and 5+2q is its window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register word address |
| wr_data | input | 32 | Register write data |
| now_sec | input | 32 | Current time, seconds |
| now_nsec | input | 30 | Current time, nanoseconds |
| link_speed | input | 3 | Link speed code |
| frame_len | input | NQ×LW (64) | Per-queue pending frame length in bytes |
| gate_open | output | NQ (4) | Per-queue gate state |
| may_start | output | NQ (4) | Per-queue permission to begin the pending frame |
| tx_ofs_ns | output | 16 | Transmit offset for the launch path |
| cfg_err_cnt | output | ERRW (8) | Saturating configuration-change error count |

## Verification
The bench drives gate edges at the exact start and end nanosecond. A window comparison with the wrong operator would move an edge by one time step. Past start times are committed with n = 0 and n = 5. A snapping error of one cycle would open or close the gates a full cycle early or late. A strict queue is offered frames that end exactly on the window end and on the cycle end, and then one step later. An off-by-one fit test would admit or refuse the wrong one. The arming write, commits while disabled, and error-counter saturation are also exercised. A design that started at once, obeyed a stale commit or wrapped the counter would show open or closed gates, or a counter value, that differ from the model.

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NQ = 4,
  parameter int LW = 16,
  parameter int ERRW = 8,
  parameter int NSW = 30,
  parameter logic [15:0] OFS_S0 = 16'd9600,
  parameter logic [15:0] OFS_S1 = 16'd960,
  parameter logic [15:0] OFS_S2 = 16'd184,
  parameter logic [15:0] OFS_S3 = 16'd72,
  localparam int AW = $clog2(4 + 2*NQ)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       now_sec,
  input  logic [NSW-1:0]    now_nsec,
  input  logic [2:0]        link_speed,
  input  logic [NQ*LW-1:0]  frame_len,
  output logic [NQ-1:0]     gate_open,
  output logic [NQ-1:0]     may_start,
  output logic [15:0]       tx_ofs_ns,
  output logic [ERRW-1:0]   cfg_err_cnt
);
  localparam logic [63:0]     NS_PER_S = 64'd1000000000;
  localparam logic [NSW-1:0]  FULL     = NSW'(1000000000);
  localparam logic [ERRW-1:0] ERR_MAX  = '1;

  logic en_r, fut_r, lt_r, run_r, snap_r, arm_r;
  logic [NQ-1:0]  strict_r;
  logic [NSW-1:0] cyc_r;
  logic [NSW-1:0] st_r [NQ];
  logic [NSW-1:0] end_r [NQ];
  logic [31:0]    bsec_r;
  logic [63:0]    anchor_r, now_t, base_t, ofs_raw, ofs, cyc64;
  logic           active, wr_base, wr_stop, arm_hit, past;
  logic [9:0]     bit_t;

  assign now_t   = {32'd0, now_sec} * NS_PER_S + 64'(now_nsec);
  assign base_t  = {32'd0, bsec_r} * NS_PER_S + 64'(wr_data[NSW-1:0]);
  assign cyc64   = 64'(cyc_r);
  assign active  = run_r && !snap_r && (now_t >= anchor_r);
  assign ofs_raw = now_t - anchor_r;
  assign ofs     = (ofs_raw >= cyc64) ? ofs_raw - cyc64 : ofs_raw;
  assign wr_base = wr_en && en_r && (wr_addr == AW'(3));
  assign wr_stop = wr_en && (wr_addr == AW'(0)) && !wr_data[0];
  assign arm_hit = fut_r && !run_r && !arm_r && (wr_data == 32'd0);
  assign past    = base_t < now_t;

  always_comb begin
    case (link_speed)
      3'd0: bit_t = 10'd1000;
      3'd1: bit_t = 10'd100;
      3'd3: bit_t = 10'd4;
      default: bit_t = 10'd10;
    endcase
    tx_ofs_ns = 16'd0;
    if (lt_r)
      case (link_speed)
        3'd0: tx_ofs_ns = OFS_S0;
        3'd1: tx_ofs_ns = OFS_S1;
        3'd2: tx_ofs_ns = OFS_S2;
        3'd3: tx_ofs_ns = OFS_S3;
        default: tx_ofs_ns = 16'd0;
      endcase
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [63:0] fin;
    logic        inwin, fits;
    assign fin   = ofs * 64'd10 + 64'(frame_len[q*LW +: LW]) * 64'd8 * 64'(bit_t);
    assign inwin = (ofs >= 64'(st_r[q])) && (ofs < 64'(end_r[q]));
    assign fits  = (fin <= 64'(end_r[q]) * 64'd10) && (fin <= cyc64 * 64'd10);
    assign gate_open[q] = !active || inwin;
    assign may_start[q] = !active || (inwin && (!strict_r[q] || fits));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en_r, fut_r, lt_r} <= '0;
      strict_r <= '0;
      cyc_r    <= FULL;
      bsec_r   <= '0;
      for (int q = 0; q < NQ; q++) begin
        st_r[q]  <= '0;
        end_r[q] <= FULL;
      end
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): begin
          en_r     <= wr_data[0];
          fut_r    <= wr_data[1];
          lt_r     <= wr_data[2];
          strict_r <= wr_data[4 +: NQ];
        end
        AW'(1): cyc_r  <= wr_data[NSW-1:0];
        AW'(2): bsec_r <= wr_data;
        default: ;
      endcase
      for (int q = 0; q < NQ; q++) begin
        if (wr_addr == AW'(4 + 2*q)) st_r[q]  <= wr_data[NSW-1:0];
        if (wr_addr == AW'(5 + 2*q)) end_r[q] <= wr_data[NSW-1:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {run_r, snap_r, arm_r} <= '0;
      anchor_r    <= '0;
      cfg_err_cnt <= '0;
    end else if (wr_stop) begin
      {run_r, snap_r, arm_r} <= '0;
    end else if (wr_base) begin
      if (arm_hit) arm_r <= 1'b1;
      else begin
        arm_r <= 1'b0;
        run_r <= 1'b1;
        if (past) begin
          anchor_r <= base_t;
          snap_r   <= 1'b1;
          if (run_r && cfg_err_cnt != ERR_MAX) cfg_err_cnt <= cfg_err_cnt + 1'b1;
        end else begin
          snap_r   <= 1'b0;
          anchor_r <= (run_r || arm_r) ? base_t : now_t;
        end
      end
    end else if (snap_r) begin
      if (anchor_r <= now_t) anchor_r <= anchor_r + cyc64;
      else snap_r <= 1'b0;
    end else if (active && ofs_raw >= cyc64) begin
      anchor_r <= anchor_r + cyc64;
    end

  p_idle_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_r |-> (&gate_open && &may_start));
  p_ofs_in_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ofs < cyc64);
  p_snap_lands_ahead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(snap_r) && !$past(wr_en)) |-> $past(anchor_r) > $past(now_t));
  p_err_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err_cnt == ERR_MAX |=> cfg_err_cnt == ERR_MAX);
  p_err_only_on_past_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_base && past && run_r) |=> $stable(cfg_err_cnt));
  p_start_needs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (may_start & ~gate_open) == '0);
  p_ofs_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lt_r |-> tx_ofs_ns == 16'd0);
endmodule

// File: tb/tas_gate_sched_tb_top.sv
module tas_gate_sched_tb_top;
  localparam int NQ = 4, LW = 16, ERRW = 4;
  localparam int EMAX = (1 << ERRW) - 1;
  localparam longint GIGA = 64'd1000000000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] now_sec;
  logic [29:0] now_nsec;
  logic [2:0] link_speed = 3'd2;
  logic [NQ*LW-1:0] frame_len = '0;
  logic [NQ-1:0] gate_open, may_start;
  logic [15:0] tx_ofs_ns;
  logic [ERRW-1:0] cfg_err_cnt;

  longint tnow = 64'd3000000000;
  int checks = 0, errors = 0;
  string req = "R1";

  assign now_sec  = 32'(tnow / GIGA);
  assign now_nsec = 30'(tnow % GIGA);

  always #2 clk = ~clk;

  tas_gate_sched #(.NQ(NQ), .LW(LW), .ERRW(ERRW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .now_sec(now_sec), .now_nsec(now_nsec), .link_speed(link_speed), .frame_len(frame_len),
    .gate_open(gate_open), .may_start(may_start), .tx_ofs_ns(tx_ofs_ns), .cfg_err_cnt(cfg_err_cnt));

  longint m_st[NQ], m_end[NQ], m_cyc, m_bsec, m_anc;
  bit m_en, m_fut, m_lt, m_run, m_arm;
  bit [NQ-1:0] m_strict;
  int m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin m_st[q] = 0; m_end[q] = GIGA; end
      m_cyc = GIGA; m_bsec = 0; m_anc = 0; m_err = 0; m_strict = '0;
      {m_en, m_fut, m_lt, m_run, m_arm} = '0;
    end else begin
      if (m_run && tnow >= m_anc)
        while (tnow - m_anc >= m_cyc) m_anc += m_cyc;
      if (wr_en) begin
        if (wr_addr == 0) begin
          m_en = wr_data[0]; m_fut = wr_data[1]; m_lt = wr_data[2]; m_strict = wr_data[7:4];
          if (!wr_data[0]) begin m_run = 0; m_arm = 0; end
        end else if (wr_addr == 1) m_cyc = longint'(wr_data[29:0]);
        else if (wr_addr == 2) m_bsec = longint'(wr_data);
        else if (wr_addr == 3) begin
          if (m_en) begin
            longint b;
            b = m_bsec * GIGA + longint'(wr_data[29:0]);
            if (m_fut && !m_run && !m_arm && wr_data == 0) m_arm = 1;
            else begin
              if (b < tnow) begin
                m_anc = b + ((tnow - b) / m_cyc + 1) * m_cyc;
                if (m_run && m_err < EMAX) m_err++;
              end else if (m_run || m_arm) m_anc = b;
              else m_anc = tnow;
              m_run = 1; m_arm = 0;
            end
          end
        end else if (wr_addr[0] == 1'b0) m_st[(wr_addr - 4) / 2] = longint'(wr_data[29:0]);
        else m_end[(wr_addr - 4) / 2] = longint'(wr_data[29:0]);
      end
    end
  end

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at t=%0d", r, what, act, exp, tnow);
    end
  endtask

  task automatic cmp();
    bit act;
    longint ofs, bt, fin, eo;
    bit [NQ-1:0] eg, em;
    act = m_run && tnow >= m_anc;
    ofs = act ? (tnow - m_anc) % m_cyc : 0;
    case (link_speed)
      3'd0: bt = 1000;
      3'd1: bt = 100;
      3'd3: bt = 4;
      default: bt = 10;
    endcase
    for (int q = 0; q < NQ; q++) begin
      bit win;
      win = ofs >= m_st[q] && ofs < m_end[q];
      fin = ofs * 10 + longint'(frame_len[q*LW +: LW]) * 8 * bt;
      eg[q] = !act || win;
      em[q] = !act || (win && (!m_strict[q] || (fin <= m_end[q] * 10 && fin <= m_cyc * 10)));
    end
    case (link_speed)
      3'd0: eo = 9600;
      3'd1: eo = 960;
      3'd2: eo = 184;
      3'd3: eo = 72;
      default: eo = 0;
    endcase
    if (!m_lt) eo = 0;
    chk(req, "gate_open", 64'(gate_open), 64'(eg));
    chk(m_strict != 0 ? "R7" : "R8", "may_start", 64'(may_start), 64'(em));
    chk("R9", "tx_ofs_ns", 64'(tx_ofs_ns), 64'(eo));
    chk("R5", "cfg_err_cnt", 64'(cfg_err_cnt), 64'(m_err));
  endtask

  task automatic step(bit w = 0, logic [3:0] a = '0, logic [31:0] d = '0);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d;
    tnow += 4;
    #1;
    cmp();
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic run_to(longint t);
    while (tnow < t) step();
  endtask

  task automatic commit(longint b);
    wr(4'd2, 32'(b / GIGA));
    wr(4'd3, 32'(b % GIGA));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint a0, c, b, ea;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1", "gate_open", 64'(gate_open), 64'hF);
    chk("R1", "may_start", 64'(may_start), 64'hF);
    chk("R1", "tx_ofs_ns", 64'(tx_ofs_ns), 0);
    chk("R1", "cfg_err_cnt", 64'(cfg_err_cnt), 0);
    repeat (5) step();

    // R11 register programming
    wr(4'd1, 1000);
    wr(4'd4, 100); wr(4'd5, 400);
    wr(4'd6, 0);   wr(4'd7, 1000);
    wr(4'd8, 500); wr(4'd9, 900);
    wr(4'd10, 996); wr(4'd11, 1000);
    wr(4'd0, 32'h1);

    req = "R5";
    b = tnow + 8 - 2000;
    commit(b);
    repeat (3) step();
    chk("R5", "err after idle past commit", 64'(cfg_err_cnt), 0);
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h1);

    req = "R6";
    wr(4'd2, 10);
    wr(4'd3, 5);
    a0 = tnow;
    step();
    chk("R6", "immediate start q2 closed", 64'(gate_open[2]), 0);
    req = "R2";
    run_to(a0 + 96);
    chk("R2", "q0 before start", 64'(gate_open[0]), 0);
    step();
    chk("R2", "q0 at start", 64'(gate_open[0]), 1);
    run_to(a0 + 396);
    chk("R2", "q0 before end", 64'(gate_open[0]), 1);
    step();
    chk("R2", "q0 at end", 64'(gate_open[0]), 0);
    run_to(a0 + 996);
    chk("R2", "q3 open late", 64'(gate_open[3]), 1);
    step();
    chk("R2", "q3 after wrap", 64'(gate_open[3]), 0);
    repeat (2500) step();

    // R7 strict fit
    frame_len = {16'd0, 16'd0, 16'd50, 16'd10};
    wr(4'd0, 32'h31);
    c = a0 + ((tnow - a0) / 1000 + 1) * 1000;
    run_to(c + 320);
    chk("R7", "q0 fits end", 64'(may_start[0]), 1);
    step();
    chk("R7", "q0 overruns end", 64'(may_start[0]), 0);
    chk("R7", "q0 gate still open", 64'(gate_open[0]), 1);
    run_to(c + 600);
    chk("R7", "q1 fits cycle", 64'(may_start[1]), 1);
    step();
    chk("R7", "q1 overruns cycle", 64'(may_start[1]), 0);
    link_speed = 3'd3; repeat (800) step();
    link_speed = 3'd0; repeat (500) step();
    link_speed = 3'd2;

    // R9 offset table
    wr(4'd0, 32'h35);
    for (int s = 0; s < 5; s++) begin
      link_speed = 3'(s);
      step();
      chk("R9", "tx offset", 64'(tx_ofs_ns), s == 0 ? 9600 : s == 1 ? 960 : s == 2 ? 184 : s == 3 ? 72 : 0);
    end
    link_speed = 3'd2;
    wr(4'd0, 32'h31);
    step();
    chk("R9", "tx offset off", 64'(tx_ofs_ns), 0);

    // R4 past snap n = 0
    req = "R4";
    b = tnow + 8 - 200;
    ea = b + 1000;
    commit(b);
    repeat (2) step();
    chk("R5", "err first past", 64'(cfg_err_cnt), 1);
    run_to(ea - 4);
    chk("R3", "pending open", 64'(gate_open), 64'hF);
    step();
    chk("R4", "n=0 start q0", 64'(gate_open[0]), 0);
    chk("R4", "n=0 start q1", 64'(gate_open[1]), 1);
    repeat (300) step();

    // R4 past snap n = 5
    b = tnow + 8 - 5300;
    ea = b + 6000;
    commit(b);
    repeat (2) step();
    chk("R5", "err second past", 64'(cfg_err_cnt), 2);
    run_to(ea - 4);
    chk("R3", "pending open n5", 64'(gate_open), 64'hF);
    step();
    chk("R4", "n=5 start q0", 64'(gate_open[0]), 0);
    run_to(ea + 100);
    chk("R4", "n=5 q0 opens", 64'(gate_open[0]), 1);

    // R5 saturation
    req = "R5";
    for (int k = 0; k < 16; k++) begin
      b = tnow + 8 - 200;
      commit(b);
      repeat (2) step();
    end
    chk("R5", "saturated", 64'(cfg_err_cnt), EMAX);
    repeat (1200) step();

    // R10 disable and ignored commit
    req = "R10";
    wr(4'd0, 32'h0);
    step();
    chk("R10", "disabled open", 64'(gate_open), 64'hF);
    commit(tnow + 500);
    wr(4'd0, 32'h1);
    repeat (1500) step();
    chk("R10", "ignored commit", 64'(gate_open), 64'hF);

    // R6 arming then future start
    req = "R6";
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h3);
    b = tnow + 3000;
    wr(4'd2, 32'(b / GIGA));
    wr(4'd3, 32'h0);
    repeat (20) step();
    chk("R6", "armed only", 64'(gate_open), 64'hF);
    wr(4'd3, 32'(b % GIGA));
    req = "R3";
    run_to(b - 4);
    chk("R3", "future pending", 64'(gate_open), 64'hF);
    step();
    chk("R6", "future start q0", 64'(gate_open[0]), 0);
    run_to(b + 100);
    chk("R3", "future q0 opens", 64'(gate_open[0]), 1);
    repeat (1500) step();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule